// File: doc/BRIEF.md
# Bounded Pseudo-Random Index Generator

This block picks a replacement slot for an address-translation cache. On each accepted request it steps a 32-bit linear congruential generator, takes the upper half of the new state as a raw value, and reduces that value into the slots that are not pinned. The lowest `wired_i` slots are pinned, so the index it delivers never selects one of them and never goes past the last slot.

The range reduction is a modulo by `ENTRY_COUNT - wired`. A parameter selects how it is built. The default is a one-bit-per-cycle restoring remainder unit. The other choice is a single registered modulo stage. While a reduction is running, `busy_o` is high and further requests are dropped. A pinned count that leaves no free slot never reaches the divider. Instead it returns the last slot at once and raises an error flag.

Top module: `rand_index_gen`

## Requirements
- R1: While `rst_n` is low and after it rises: `index_o` = ENTRY_COUNT-1 (47 by default), `valid_o`, `busy_o` and `err_o` are 0, and the generator state is zero.
- R2: Each accepted request replaces the 32-bit state with (state × 314159 + 1) mod 2^32, and the new value is used for that request. With state starting at zero, the first raw value after reset is 0.
- R3: For a request with `wired_i` < ENTRY_COUNT, the raw value is bits 31..16 of the new state, and `index_o` becomes (raw mod (ENTRY_COUNT − wired_i)) + wired_i.
- R4: Whenever `valid_o` is high and `err_o` is low, wired_i ≤ `index_o` ≤ ENTRY_COUNT-1, where wired_i is the value captured at acceptance.
- R5: A request is accepted on a rising edge where `req_i` is high and `busy_o` is low. For a non-error request, `busy_o` is high from that edge. `index_o` updates, with a one-cycle `valid_o` pulse, on edge RAW_W+1 after it (17 with defaults, sequential variant). `busy_o` falls on that same edge.
- R6: A request raised while `busy_o` is high is ignored. It neither steps the state nor replaces the captured pinned count, so the pending result and the next one follow the single-step sequence.
- R7: If `wired_i` ≥ ENTRY_COUNT at acceptance, `index_o` becomes ENTRY_COUNT-1 and `err_o` and `valid_o` rise on the acceptance edge itself. `busy_o` stays low, no division is started, and the state still steps once.
- R8: `err_o` holds until the next delivered result and is cleared by a non-error result.
- R9: `wired_i` = ENTRY_COUNT-1 is legal and yields `index_o` = ENTRY_COUNT-1 with `err_o` low.
- R10: Reset has priority over a simultaneous request. A request held high during reset does not step the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request for a new index |
| wired_i | input | IDX_W (6) | Number of pinned low slots, sampled at acceptance |
| index_o | output | IDX_W (6) | Last delivered slot index |
| valid_o | output | 1 | One-cycle pulse when `index_o` is updated |
| busy_o | output | 1 | Reduction in progress; requests ignored |
| err_o | output | 1 | Pinned count left no free slot for the last result |

## Verification
A normal result is due 17 edges after the acceptance edge. An error result is due on the acceptance edge itself. The bench drives each request on a falling edge and then counts falling edges until `valid_o` appears. It compares that count with 17 or 0, so a result that comes early or late fails the check even if its value is right. All output values are sampled on falling edges, half a cycle after the edge that changes them. Ignored requests are injected a few cycles into the busy window, well before the result is due.

// File: rtl/rig_pkg.sv
package rig_pkg;

   // One step of the multiply-add recurrence, truncated to the state width.
   function automatic logic [31:0] lcg_step(input logic [31:0] s,
                                            input logic [31:0] mul,
                                            input logic [31:0] inc);
      return s * mul + inc;
   endfunction

   typedef enum logic {
      RED_COMB = 1'b0,
      RED_SEQ  = 1'b1
   } red_style_e;

endpackage

// File: rtl/rig_lcg.sv
module rig_lcg #(
   parameter int unsigned STATE_W = 32,
   parameter int unsigned MULT    = 314159,
   parameter int unsigned INCR    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv_i,
   output logic [STATE_W-1:0] state_o,
   output logic [STATE_W-1:0] next_o
);
   import rig_pkg::*;

   logic [STATE_W-1:0] state_q;
   logic [31:0]        step_w;

   if (STATE_W != 32) begin : g_bad_width
      $error("rig_lcg: STATE_W must be 32");
   end

   assign step_w  = lcg_step(32'(state_q), 32'(MULT), 32'(INCR));
   assign next_o  = STATE_W'(step_w);
   assign state_o = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (adv_i) begin
         state_q <= next_o;
      end
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(state_q));

endmodule

// File: rtl/rig_mod_seq.sv
module rig_mod_seq #(
   parameter int unsigned RAW_W = 16,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [RAW_W-1:0] dividend_i,
   input  logic [IDX_W:0]   divisor_i,
   output logic             done_o,
   output logic [IDX_W-1:0] rem_o
);
   localparam int unsigned CNT_W = $clog2(RAW_W + 1);

   logic [RAW_W-1:0] dvd_q;
   logic [IDX_W:0]   dvs_q;
   logic [IDX_W-1:0] rem_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             done_q;
   logic [IDX_W:0]   trial_w;
   logic [IDX_W-1:0] step_rem_w;

   // Bring down one dividend bit and subtract the divisor if it fits.
   always_comb begin
      trial_w = {rem_q, dvd_q[RAW_W-1]};
      if (trial_w >= dvs_q) begin
         step_rem_w = IDX_W'(trial_w - dvs_q);
      end else begin
         step_rem_w = IDX_W'(trial_w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q  <= '0;
         dvs_q  <= '0;
         rem_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start_i) begin
         dvd_q  <= dividend_i;
         dvs_q  <= divisor_i;
         rem_q  <= '0;
         cnt_q  <= CNT_W'(RAW_W);
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         rem_q <= step_rem_w;
         dvd_q <= dvd_q << 1;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end else begin
            done_q <= 1'b0;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done_o = done_q;
   assign rem_o  = rem_q;

   // R3
   rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ({1'b0, rem_q} < dvs_q));

   // R5
   run_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/rig_mod_comb.sv
module rig_mod_comb #(
   parameter int unsigned RAW_W = 16,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [RAW_W-1:0] dividend_i,
   input  logic [IDX_W:0]   divisor_i,
   output logic             done_o,
   output logic [IDX_W-1:0] rem_o
);
   logic [IDX_W-1:0] rem_q;
   logic             done_q;
   logic [RAW_W-1:0] quot_rem_w;

   if (RAW_W < IDX_W + 1) begin : g_bad_width
      $error("rig_mod_comb: RAW_W must cover the divisor width");
   end

   assign quot_rem_w = (divisor_i == '0) ? '0 : (dividend_i % RAW_W'(divisor_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= start_i;
         if (start_i) begin
            rem_q <= IDX_W'(quot_rem_w);
         end
      end
   end

   assign done_o = done_q;
   assign rem_o  = rem_q;

   // R5
   comb_done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_q);

endmodule

// File: rtl/rand_index_gen.sv
module rand_index_gen #(
   parameter int unsigned ENTRY_COUNT = 48,
   parameter int unsigned STATE_W     = 32,
   parameter int unsigned SHIFT       = 16,
   parameter int unsigned MULT        = 314159,
   parameter int unsigned INCR        = 1,
   parameter bit          SEQ_REDUCE  = 1'b1,
   localparam int unsigned IDX_W      = $clog2(ENTRY_COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [IDX_W-1:0] wired_i,
   output logic [IDX_W-1:0] index_o,
   output logic             valid_o,
   output logic             busy_o,
   output logic             err_o
);
   import rig_pkg::*;

   localparam int unsigned RAW_W = STATE_W - SHIFT;
   localparam int unsigned DIV_W = IDX_W + 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_COUNT - 1);
   localparam red_style_e STYLE = SEQ_REDUCE ? RED_SEQ : RED_COMB;

   if (ENTRY_COUNT < 2) begin : g_bad_count
      $error("rand_index_gen: ENTRY_COUNT must be at least 2");
   end
   if (SHIFT >= STATE_W) begin : g_bad_shift
      $error("rand_index_gen: SHIFT must leave raw bits");
   end
   if (RAW_W < DIV_W) begin : g_bad_raw
      $error("rand_index_gen: raw value narrower than divisor");
   end

   logic [STATE_W-1:0] state_w;
   logic [STATE_W-1:0] next_w;
   logic [RAW_W-1:0]   raw_w;
   logic [DIV_W-1:0]   span_w;
   logic               wired_bad_w;
   logic               accept_w;
   logic               start_w;
   logic               mod_done_w;
   logic [IDX_W-1:0]   mod_rem_w;

   logic               busy_q;
   logic               valid_q;
   logic               err_q;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   wired_q;

   assign accept_w    = req_i && !busy_q;
   assign wired_bad_w = {1'b0, wired_i} >= DIV_W'(ENTRY_COUNT);
   assign span_w      = DIV_W'(ENTRY_COUNT) - {1'b0, wired_i};
   assign start_w     = accept_w && !wired_bad_w;
   assign raw_w       = next_w[STATE_W-1:SHIFT];

   rig_lcg #(
      .STATE_W (STATE_W),
      .MULT    (MULT),
      .INCR    (INCR)
   ) u_lcg (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (accept_w),
      .state_o (state_w),
      .next_o  (next_w)
   );

   if (STYLE == RED_SEQ) begin : g_seq
      rig_mod_seq #(
         .RAW_W (RAW_W),
         .IDX_W (IDX_W)
      ) u_mod (
         .clk        (clk),
         .rst_n      (rst_n),
         .start_i    (start_w),
         .dividend_i (raw_w),
         .divisor_i  (span_w),
         .done_o     (mod_done_w),
         .rem_o      (mod_rem_w)
      );
   end else begin : g_comb
      rig_mod_comb #(
         .RAW_W (RAW_W),
         .IDX_W (IDX_W)
      ) u_mod (
         .clk        (clk),
         .rst_n      (rst_n),
         .start_i    (start_w),
         .dividend_i (raw_w),
         .divisor_i  (span_w),
         .done_o     (mod_done_w),
         .rem_o      (mod_rem_w)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         idx_q   <= LAST_IDX;
         wired_q <= '0;
      end else begin
         valid_q <= 1'b0;
         if (accept_w) begin
            if (wired_bad_w) begin
               idx_q   <= LAST_IDX;
               err_q   <= 1'b1;
               valid_q <= 1'b1;
            end else begin
               busy_q  <= 1'b1;
               wired_q <= wired_i;
            end
         end else if (busy_q && mod_done_w) begin
            idx_q   <= mod_rem_w + wired_q;
            err_q   <= 1'b0;
            valid_q <= 1'b1;
            busy_q  <= 1'b0;
         end
      end
   end

   assign index_o = idx_q;
   assign valid_o = valid_q;
   assign busy_o  = busy_q;
   assign err_o   = err_q;

   // R4
   index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !err_q) |-> (idx_q >= wired_q && idx_q <= LAST_IDX));

   // R7
   err_gives_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && err_q) |-> (idx_q == LAST_IDX));

   // R6
   busy_freezes_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(state_w));

   // R6
   busy_keeps_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(wired_q));

   // R7
   bad_wired_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_w && wired_bad_w) |=> (!busy_q && valid_q && err_q));

endmodule

// File: tb/rand_index_gen_bench.sv
module rand_index_gen_bench;
   localparam int ENTRIES = 48;
   localparam int LAT     = 17;
   localparam int NVEC    = 10;

   // {expect_error, wired}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b0_000000, 7'b0_000101, 7'b0_010100, 7'b0_101111, 7'b1_110010,
      7'b0_000011, 7'b0_000000, 7'b1_111111, 7'b0_011110, 7'b0_101110
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [5:0] wired = '0;
   logic [5:0] index;
   logic       valid, busy, err;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model_st = '0;

   always #4 clk = ~clk;

   rand_index_gen u_rand_index_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .wired_i (wired),
      .index_o (index),
      .valid_o (valid),
      .busy_o  (busy),
      .err_o   (err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Issue one request; poke=1 raises extra requests while busy.
   task automatic run_req(input logic [5:0] w, input bit exp_err, input bit poke,
                          input string tag);
      int k;
      int exp_idx;
      logic [15:0] raw;
      @(negedge clk);
      req   = 1'b1;
      wired = w;
      @(posedge clk);
      model_st = model_st * 32'd314159 + 32'd1;
      raw = model_st[31:16];
      exp_idx = exp_err ? ENTRIES - 1 : (int'(raw) % (ENTRIES - int'(w))) + int'(w);
      @(negedge clk);
      req = 1'b0;
      k = 0;
      if (!exp_err) check(busy == 1'b1, {tag, " R5 busy after accept"}, busy, 1);
      while (!valid && k < 60) begin
         @(negedge clk);
         k++;
         if (poke && k == 2) begin req = 1'b1; wired = 6'd40; end
         if (poke && k == 4) req = 1'b0;
      end
      check(k == (exp_err ? 0 : LAT), {tag, " R5 latency"}, k, exp_err ? 0 : LAT);
      check(int'(index) == exp_idx, {tag, " R3 index"}, index, exp_idx);
      check(err == exp_err, {tag, " R7/R8 err"}, err, exp_err);
      if (!exp_err)
         check(index >= w && int'(index) <= ENTRIES - 1, {tag, " R4 range"}, index, w);
      @(negedge clk);
      check(valid == 1'b0, {tag, " R5 valid pulse"}, valid, 0);
      check(busy == 1'b0, {tag, " R5 busy released"}, busy, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check(index == 6'd47 && !valid && !busy && !err, "R1 reset outputs", index, 47);
      rst_n = 1'b1;

      // R2: first request after reset sees raw value 0, so index equals wired
      for (int i = 0; i < NVEC; i++) begin
         run_req(VEC[i][5:0], VEC[i][6], 1'b0, $sformatf("R2 vec%0d", i));
      end

      // R6: extra requests during busy are dropped
      run_req(6'd3, 1'b0, 1'b1, "R6 poke");
      run_req(6'd7, 1'b0, 1'b0, "R6 follow");

      // R7 then R8: error result, then a normal one clears it
      run_req(6'd55, 1'b1, 1'b0, "R7 bad wired");
      run_req(6'd1, 1'b0, 1'b0, "R8 clear");

      // R9: only the last slot is free
      run_req(6'd47, 1'b0, 1'b0, "R9 single slot");
      check(index == 6'd47, "R9 last slot", index, 47);

      // R10: request held through reset does not step the state
      @(negedge clk);
      rst_n = 1'b0;
      req   = 1'b1;
      wired = 6'd0;
      repeat (3) @(negedge clk);
      check(index == 6'd47 && !busy && !valid && !err, "R10 reset wins", index, 47);
      req = 1'b0;
      rst_n = 1'b1;
      model_st = '0;
      run_req(6'd9, 1'b0, 1'b0, "R10 first after reset");
      check(index == 6'd9, "R10 raw zero", index, 9);
      run_req(6'd10, 1'b0, 1'b0, "R10 second after reset");
      check(index == 6'd14, "R2 second raw", index, 14);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule